// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Arbitration

This block is a synchronous memory with two identical access ports, called left and right. Either port can read or write any word. A word written through one port can be read back through the other port starting in the next cycle. Each port has an active-low select, an active-low write strobe and an active-low read-output enable. The word geometry is set by parameters. The full configuration has a 15-bit address and 16-bit words (32K words), and the default build uses a smaller depth of the same shape.

A strap input sets the role of the block. As master, the block compares the two addresses itself. When both enabled ports present the same word, the port that arrived there first keeps the word. If both arrive in the same cycle, the left port keeps it. The other port is shown a busy flag. As slave, the block does no comparison. It obeys busy levels supplied by an external master, so that several of these blocks can be cascaded to build wider words. In both roles, a write from a busy port is dropped and never reaches the array. The host sees the busy flag and must repeat the write. A read from a busy port still returns data.

Top module: `dpram_arb`

## Requirements
- R1: A port with select low and write strobe low, and not busy, stores its write data at its address on the rising clock edge.
- R2: A port with select low and write strobe high shows the addressed word on its read data output in the same cycle. A word written by the opposite port is visible from the cycle after that port's write edge.
- R3: Read data is driven, and the read-drive flag is 1, only when select is low, output enable is low and write strobe is high. Otherwise read data is all zeros and the flag is 0. After reset, with both ports idle, both busy outputs are 0.
- R4: In master mode, when both ports are selected at the same address, exactly one busy output is 1 (the losing port) in that same cycle. The winning port's busy output is 0.
- R5: In master mode, a port that was already selected at that address in the previous cycle wins against a port that has just arrived.
- R6: In master mode, when both ports arrive at the same address in the same cycle, the left port wins. The winner keeps the word for as long as both ports stay selected at that address.
- R7: The loser's busy output returns to 0 in the first cycle in which the winner is deselected or presents a different address.
- R8: A write from a port whose effective busy is 1 is dropped. It is not stored later when busy falls.
- R9: A port that loses arbitration while reading still receives the addressed word on its read data output.
- R10: In slave mode, both busy outputs are 0, address equality has no effect, and each port's busy input alone blocks that port's writes.
- R11: When both ports write the same address in the same cycle with neither blocked (slave mode, busy inputs low), the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the arbitration state |
| master_sel | input | 1 | Strap: 1 = master (internal arbitration), 0 = slave (external busy) |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, active low (high = read) |
| l_oe_n | input | 1 | Left read-output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero when not driven |
| l_rd_drive | output | 1 | Left read data is being driven |
| l_busy_in | input | 1 | Left busy from an external master (slave mode) |
| l_busy_out | output | 1 | Left busy generated in master mode |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, active low (high = read) |
| r_oe_n | input | 1 | Right read-output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero when not driven |
| r_rd_drive | output | 1 | Right read data is being driven |
| r_busy_in | input | 1 | Right busy from an external master (slave mode) |
| r_busy_out | output | 1 | Right busy generated in master mode |

## Verification
The arbitration state is a remembered winner plus one arrival flag per port. If the remembered winner is corrupted, the wrong busy output rises in the very next cycle of a continuing collision. The symptom lasts one cycle later, when a write that should have been dropped shows up in a read from the opposite port. A wrong arrival flag shows up as a swapped busy pair in the first cycle of a collision. A write that should have been blocked but was stored appears as changed read data on the other port one cycle after the edge. For this reason the stimulus always follows a blocked write with a read of the same word.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int unsigned NUM_PORTS  = 2;
   localparam int unsigned PORT_L     = 0;
   localparam int unsigned PORT_R     = 1;
   localparam int unsigned MAX_ADDR_W = 15;

endpackage

// File: rtl/dpram_arb_store.sv
// Word array with two write ports and two combinational read ports.
module dpram_arb_store #(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned DATA_W    = 16,
   parameter bit          LEFT_LAST = 1'b1
) (
   input  logic                          clk,
   input  logic [1:0]                    wr_en,
   input  logic [1:0][ADDR_W-1:0]        addr,
   input  logic [1:0][DATA_W-1:0]        wdata,
   output logic [1:0][DATA_W-1:0]        rd
);
   import dpram_arb_pkg::*;

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Write order decides which port owns a same-word double write.
   if (LEFT_LAST) begin : g_left_last
      always_ff @(posedge clk) begin
         if (wr_en[PORT_R]) mem[addr[PORT_R]] <= wdata[PORT_R];
         if (wr_en[PORT_L]) mem[addr[PORT_L]] <= wdata[PORT_L];
      end
   end else begin : g_right_last
      always_ff @(posedge clk) begin
         if (wr_en[PORT_L]) mem[addr[PORT_L]] <= wdata[PORT_L];
         if (wr_en[PORT_R]) mem[addr[PORT_R]] <= wdata[PORT_R];
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
      assign rd[p] = mem[addr[p]];
   end

endmodule

// File: rtl/dpram_arb_resolve.sv
// Same-address arbitration: arrival tracking plus a remembered winner.
module dpram_arb_resolve #(
   parameter int unsigned ADDR_W   = 10,
   parameter bit          TIE_LEFT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             act,
   input  logic [1:0][ADDR_W-1:0] addr,
   output logic                   collide,
   output logic [1:0]             lose
);
   import dpram_arb_pkg::*;

   logic [1:0]             prev_act_q;
   logic [1:0][ADDR_W-1:0] prev_addr_q;
   logic [1:0]             held;
   owner_e                 owner_q;
   owner_e                 owner_d;
   owner_e                 tie_owner;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_held
      assign held[p] = act[p] & prev_act_q[p] & (prev_addr_q[p] == addr[p]);
   end

   assign collide = act[PORT_L] & act[PORT_R] & (addr[PORT_L] == addr[PORT_R]);

   if (TIE_LEFT) begin : g_tie_l
      assign tie_owner = OWN_LEFT;
   end else begin : g_tie_r
      assign tie_owner = OWN_RIGHT;
   end

   always_comb begin
      owner_d = OWN_NONE;
      if (collide) begin
         unique case (held)
            2'b01:   owner_d = OWN_LEFT;
            2'b10:   owner_d = OWN_RIGHT;
            2'b11:   owner_d = (owner_q == OWN_NONE) ? tie_owner : owner_q;
            default: owner_d = tie_owner;
         endcase
      end
   end

   assign lose[PORT_L] = (owner_d == OWN_RIGHT);
   assign lose[PORT_R] = (owner_d == OWN_LEFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_act_q  <= '0;
         prev_addr_q <= '0;
         owner_q     <= OWN_NONE;
      end else begin
         prev_act_q  <= act;
         prev_addr_q <= addr;
         owner_q     <= owner_d;
      end
   end

endmodule

// File: rtl/dpram_arb_port.sv
// Per-port control: busy source selection, write gating, read drive.
module dpram_arb_port #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              master,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              lose,
   input  logic              busy_in,
   input  logic [DATA_W-1:0] mem_q,
   output logic              act,
   output logic              wr_en,
   output logic              busy_out,
   output logic              rd_drive,
   output logic [DATA_W-1:0] rdata
);
   logic busy_eff;

   assign act      = ~cs_n;
   assign busy_eff = master ? lose : busy_in;
   assign busy_out = master & lose;
   assign wr_en    = act & ~we_n & ~busy_eff;
   assign rd_drive = act & we_n & ~oe_n;
   assign rdata    = rd_drive ? mem_q : '0;

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned DATA_W    = 16,
   parameter bit          TIE_LEFT  = 1'b1,
   parameter bit          LEFT_LAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_sel,
   input  logic              l_cs_n,
   input  logic              l_we_n,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rd_drive,
   input  logic              l_busy_in,
   output logic              l_busy_out,
   input  logic              r_cs_n,
   input  logic              r_we_n,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rd_drive,
   input  logic              r_busy_in,
   output logic              r_busy_out
);
   import dpram_arb_pkg::*;

   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
      $error("dpram_arb: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dpram_arb: DATA_W must be positive");
   end

   logic [1:0]             cs_n_v, we_n_v, oe_n_v, busy_in_v;
   logic [1:0][ADDR_W-1:0] addr_v;
   logic [1:0][DATA_W-1:0] wdata_v, mem_q_v, rdata_v;
   logic [1:0]             act_v, wr_en_v, lose_v, busy_out_v, drive_v;
   logic                   collide;

   assign cs_n_v    = {r_cs_n, l_cs_n};
   assign we_n_v    = {r_we_n, l_we_n};
   assign oe_n_v    = {r_oe_n, l_oe_n};
   assign busy_in_v = {r_busy_in, l_busy_in};
   assign addr_v    = {r_addr, l_addr};
   assign wdata_v   = {r_wdata, l_wdata};

   dpram_arb_resolve #(.ADDR_W(ADDR_W), .TIE_LEFT(TIE_LEFT)) resolve_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act_v),
      .addr    (addr_v),
      .collide (collide),
      .lose    (lose_v)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      dpram_arb_port #(.DATA_W(DATA_W)) port_i (
         .master   (master_sel),
         .cs_n     (cs_n_v[p]),
         .we_n     (we_n_v[p]),
         .oe_n     (oe_n_v[p]),
         .lose     (lose_v[p] & collide),
         .busy_in  (busy_in_v[p]),
         .mem_q    (mem_q_v[p]),
         .act      (act_v[p]),
         .wr_en    (wr_en_v[p]),
         .busy_out (busy_out_v[p]),
         .rd_drive (drive_v[p]),
         .rdata    (rdata_v[p])
      );
   end

   dpram_arb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEFT_LAST(LEFT_LAST)) store_i (
      .clk   (clk),
      .wr_en (wr_en_v),
      .addr  (addr_v),
      .wdata (wdata_v),
      .rd    (mem_q_v)
   );

   assign l_rdata    = rdata_v[PORT_L];
   assign r_rdata    = rdata_v[PORT_R];
   assign l_rd_drive = drive_v[PORT_L];
   assign r_rd_drive = drive_v[PORT_R];
   assign l_busy_out = busy_out_v[PORT_L];
   assign r_busy_out = busy_out_v[PORT_R];

endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_sel,
   input logic              l_cs_n,
   input logic              l_we_n,
   input logic              l_oe_n,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_rd_drive,
   input logic              l_busy_out,
   input logic              r_cs_n,
   input logic              r_we_n,
   input logic              r_oe_n,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_rd_drive,
   input logic              r_busy_out
);

   p_busy_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
      master_sel |-> !(l_busy_out && r_busy_out));

   p_busy_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && (l_busy_out || r_busy_out)) |->
         (!l_cs_n && !r_cs_n && (l_addr == r_addr)));

   p_owner_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && $past(master_sel) && $past(l_busy_out) &&
       $past(!l_cs_n && !r_cs_n) && !l_cs_n && !r_cs_n &&
       $stable(l_addr) && $stable(r_addr)) |-> l_busy_out);

   p_release_left_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      l_cs_n |-> !r_busy_out);

   p_release_right_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      r_cs_n |-> !l_busy_out);

   p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !master_sel |-> (!l_busy_out && !r_busy_out));

   p_left_drive_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (l_cs_n || l_oe_n || !l_we_n) |-> (!l_rd_drive && (l_rdata == '0)));

   p_right_drive_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (r_cs_n || r_oe_n || !r_we_n) |-> (!r_rd_drive && (r_rdata == '0)));

endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .master_sel (master_sel),
   .l_cs_n     (l_cs_n),
   .l_we_n     (l_we_n),
   .l_oe_n     (l_oe_n),
   .l_addr     (l_addr),
   .l_rdata    (l_rdata),
   .l_rd_drive (l_rd_drive),
   .l_busy_out (l_busy_out),
   .r_cs_n     (r_cs_n),
   .r_we_n     (r_we_n),
   .r_oe_n     (r_oe_n),
   .r_addr     (r_addr),
   .r_rdata    (r_rdata),
   .r_rd_drive (r_rd_drive),
   .r_busy_out (r_busy_out)
);

// File: tb/dpram_arb_tb_top.sv
module dpram_arb_tb_top;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned AW = 10;
   localparam int unsigned DW = 16;

   typedef struct packed {
      logic          m;
      logic          lcs, lwe, loe;
      logic [AW-1:0] la;
      logic [DW-1:0] ld;
      logic          rcs, rwe, roe;
      logic [AW-1:0] ra;
      logic [DW-1:0] rd;
      logic          bil, bir;
      logic          ebl, ebr;
      logic [DW-1:0] xl, xr;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{1,0,0,1, 5,16'h1111, 1,1,1, 0,16'h0000, 0,0, 0,0, 16'h0000,16'h0000},
      '{1,1,1,1, 0,16'h0000, 0,1,0, 5,16'h0000, 0,0, 0,0, 16'h0000,16'h1111},
      '{1,0,1,0, 5,16'h0000, 0,0,1, 6,16'h2222, 0,0, 0,0, 16'h1111,16'h0000},
      '{1,0,1,0, 6,16'h0000, 1,1,1, 0,16'h0000, 0,0, 0,0, 16'h2222,16'h0000},
      '{1,0,0,1, 7,16'h3333, 0,0,1, 7,16'h4444, 0,0, 0,1, 16'h0000,16'h0000},
      '{1,0,1,0, 7,16'h0000, 1,1,1, 0,16'h0000, 0,0, 0,0, 16'h3333,16'h0000},
      '{1,1,1,1, 0,16'h0000, 0,1,0, 5,16'h0000, 0,0, 0,0, 16'h0000,16'h1111},
      '{1,0,0,1, 5,16'h5555, 0,1,0, 5,16'h0000, 0,0, 1,0, 16'h0000,16'h1111},
      '{1,0,0,1, 5,16'h5555, 0,1,0, 5,16'h0000, 0,0, 1,0, 16'h0000,16'h1111},
      '{1,0,0,1, 5,16'h5555, 0,1,0, 6,16'h0000, 0,0, 0,0, 16'h0000,16'h2222},
      '{1,1,1,1, 0,16'h0000, 0,1,0, 5,16'h0000, 0,0, 0,0, 16'h0000,16'h5555},
      '{1,0,0,1, 9,16'h6666, 1,1,1, 0,16'h0000, 0,0, 0,0, 16'h0000,16'h0000},
      '{1,0,1,0, 9,16'h0000, 1,1,1, 0,16'h0000, 0,0, 0,0, 16'h6666,16'h0000},
      '{1,0,1,0, 9,16'h0000, 0,1,0, 9,16'h0000, 0,0, 0,1, 16'h6666,16'h6666},
      '{1,1,1,0, 9,16'h0000, 0,1,0, 9,16'h0000, 0,0, 0,0, 16'h0000,16'h6666},
      '{1,0,1,1, 9,16'h0000, 1,1,0, 9,16'h0000, 0,0, 0,0, 16'h0000,16'h0000},
      '{0,0,0,1,10,16'h7777, 0,0,1, 5,16'h8888, 0,1, 0,0, 16'h0000,16'h0000},
      '{0,0,1,0,10,16'h0000, 0,1,0, 5,16'h0000, 0,0, 0,0, 16'h7777,16'h5555},
      '{0,0,1,0, 5,16'h0000, 0,1,0, 5,16'h0000, 0,0, 0,0, 16'h5555,16'h5555},
      '{0,0,0,1,12,16'hAAAA, 0,0,1,12,16'hBBBB, 0,0, 0,0, 16'h0000,16'h0000},
      '{0,0,1,0,12,16'h0000, 0,1,0,12,16'h0000, 0,0, 0,0, 16'hAAAA,16'hAAAA}
   };

   function automatic string tag_of(int i);
      case (i)
         0, 11:          return "R1";
         1, 2, 3, 6, 12: return "R2";
         4, 8:           return "R6";
         5, 10:          return "R8";
         7:              return "R5";
         9, 14:          return "R7";
         13:             return "R9";
         15:             return "R3";
         16, 17, 18:     return "R10";
         default:        return "R11";
      endcase
   endfunction

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_sel = 1'b1;
   logic          l_cs_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1;
   logic [AW-1:0] l_addr = '0;
   logic [DW-1:0] l_wdata = '0;
   logic [DW-1:0] l_rdata;
   logic          l_rd_drive, l_busy_out;
   logic          l_busy_in = 1'b0;
   logic          r_cs_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1;
   logic [AW-1:0] r_addr = '0;
   logic [DW-1:0] r_wdata = '0;
   logic [DW-1:0] r_rdata;
   logic          r_rd_drive, r_busy_out;
   logic          r_busy_in = 1'b0;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_sel (master_sel),
      .l_cs_n     (l_cs_n),
      .l_we_n     (l_we_n),
      .l_oe_n     (l_oe_n),
      .l_addr     (l_addr),
      .l_wdata    (l_wdata),
      .l_rdata    (l_rdata),
      .l_rd_drive (l_rd_drive),
      .l_busy_in  (l_busy_in),
      .l_busy_out (l_busy_out),
      .r_cs_n     (r_cs_n),
      .r_we_n     (r_we_n),
      .r_oe_n     (r_oe_n),
      .r_addr     (r_addr),
      .r_wdata    (r_wdata),
      .r_rdata    (r_rdata),
      .r_rd_drive (r_rd_drive),
      .r_busy_in  (r_busy_in),
      .r_busy_out (r_busy_out)
   );

   task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic apply(vec_t v);
      master_sel = v.m;
      l_cs_n = v.lcs; l_we_n = v.lwe; l_oe_n = v.loe; l_addr = v.la; l_wdata = v.ld;
      r_cs_n = v.rcs; r_we_n = v.rwe; r_oe_n = v.roe; r_addr = v.ra; r_wdata = v.rd;
      l_busy_in = v.bil; r_busy_in = v.bir;
   endtask

   task automatic idle_both();
      l_cs_n = 1'b1; l_we_n = 1'b1; l_oe_n = 1'b1;
      r_cs_n = 1'b1; r_we_n = 1'b1; r_oe_n = 1'b1;
      l_busy_in = 1'b0; r_busy_in = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 2000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R3: idle outputs after reset
      check("R3", "reset l_busy_out", {31'd0, l_busy_out}, 32'd0);
      check("R3", "reset r_busy_out", {31'd0, r_busy_out}, 32'd0);
      check("R3", "reset l_rdata", {16'd0, l_rdata}, 32'd0);
      check("R3", "reset r_rd_drive", {31'd0, r_rd_drive}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VECS[i]);
         #1;
         check(tag_of(i), "l_busy_out", {31'd0, l_busy_out}, {31'd0, VECS[i].ebl});
         check(tag_of(i), "r_busy_out", {31'd0, r_busy_out}, {31'd0, VECS[i].ebr});
         check(tag_of(i), "l_rdata", {16'd0, l_rdata}, {16'd0, VECS[i].xl});
         check(tag_of(i), "r_rdata", {16'd0, r_rdata}, {16'd0, VECS[i].xr});
      end

      // R4: fresh same-cycle collision in master mode, mirrored busy pair
      @(negedge clk);
      master_sel = 1'b1;
      idle_both();
      @(negedge clk);
      l_cs_n = 1'b0; l_oe_n = 1'b0; l_addr = 10'd5;
      r_cs_n = 1'b0; r_oe_n = 1'b0; r_addr = 10'd5;
      #1;
      check("R4", "winner l_busy_out", {31'd0, l_busy_out}, 32'd0);
      check("R4", "loser r_busy_out", {31'd0, r_busy_out}, 32'd1);
      check("R9", "loser r_rdata", {16'd0, r_rdata}, 32'h5555);

      // R5: right moves away then back; left stays and becomes the earlier one
      @(negedge clk);
      r_addr = 10'd6;
      #1;
      check("R7", "r_busy_out after move", {31'd0, r_busy_out}, 32'd0);
      @(negedge clk);
      r_addr = 10'd5; r_we_n = 1'b0; r_oe_n = 1'b1; r_wdata = 16'hCCCC;
      #1;
      check("R5", "late right r_busy_out", {31'd0, r_busy_out}, 32'd1);
      @(negedge clk);
      idle_both();
      l_cs_n = 1'b0; l_oe_n = 1'b0; l_addr = 10'd5;
      #1;
      check("R8", "dropped right write", {16'd0, l_rdata}, 32'h5555);

      @(negedge clk);
      idle_both();
      finish_run();
   end

endmodule